// File: doc/BRIEF.md
# PHY SuperSpeed Calibration Write Sequencer

This block tunes a USB 3.0 PHY through its indirect control-register port. On a calibration request it issues three register writes in a fixed order. The first write overrides the loss-of-signal detector. The second raises the transmit boost. The third sets the receiver-detect measurement time, and its value is chosen from the reference-clock frequency code. Each write is handed to a port master as an address/data pair. The port master performs the low-level handshake and answers with `port_done` or `port_error`.

A request that names the other PHY instance (SuperSpeed pipe side) needs no tuning and completes at once. The frequency code is captured when the sequence starts. A failing write ends the run. The block then reports which of the three steps failed, and that report stays visible until the next request.

Top module: `phy_cal_seq`

## Requirements
- R1: After reset `busy`, `port_req`, `cal_done`, `cal_error` are 0 and `failed_step` is 0.
- R2: The first write uses address 0x0015 and data 0xA409: bias 5 in bits [15:13], enable in bit 10, level 9 in bits [4:0].
- R3: The second write uses address 0x0012 and data 0xA000: boost level 5 in bits [15:13].
- R4: The third write uses address 0x1010 and data equal to a measurement time shifted left by 4. The time is 0x20 for code 7, 0x04 for codes 3 and 4, and 0x08 for every other code. The data is therefore 0x0200, 0x0040 or 0x0080.
- R5: The writes are issued strictly in the order 1, 2, 3, with exactly one write per port response. `port_req` stays high with stable `port_addr`/`port_data` until `port_done` or `port_error` arrives.
- R6: When step n returns `port_error`, no later step is issued. `cal_error` becomes 1 and `failed_step` becomes n (encoded 1, 2 or 3). Both stay held until the next accepted request.
- R7: On a run that ends, `cal_done` pulses for exactly one cycle, in the cycle after the last response. After a full success `cal_error` is 0. `busy` is high from the cycle after the start until `cal_done`.
- R8: A request with `cal_target`=1 (the non-high-speed instance) issues no write. It raises `cal_done` in the following cycle with `cal_error`=0.
- R9: The frequency code is captured when a run starts. Changes on `freq_code` during the run do not alter the third write.
- R10: If `port_done` and `port_error` arrive in the same cycle, the response is treated as a failure of that step.
- R11: A `cal_start` while `busy` is ignored. It issues no extra writes and produces no extra `cal_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Calibration request, one cycle |
| cal_target | input | 1 | 0 = high-speed instance (run sequence), 1 = other instance |
| freq_code | input | 3 | Reference-clock frequency select code |
| port_req | output | 1 | Write request to the port master |
| port_addr | output | 16 | Control-register address of the current write |
| port_data | output | 16 | Data of the current write |
| port_done | input | 1 | Port master reports the write completed |
| port_error | input | 1 | Port master reports the write failed |
| busy | output | 1 | Sequence in progress |
| cal_done | output | 1 | One-cycle pulse at the end of a request |
| cal_error | output | 1 | Last request failed |
| failed_step | output | 2 | Failing step 1..3, valid while `cal_error` is 1 |

## Verification
Two events can coincide on a single clock edge. One is a success and a failure response on the same step. The other is a fresh calibration request arriving while a run is still waiting on the port. The first is provoked by a port model that raises `port_done` and `port_error` together on a chosen step. It is judged by the abort: no later write may follow, and `failed_step` must name that step. The second is provoked by pulsing `cal_start` in the middle of a slow run. It is judged by the count of writes and by the single `cal_done` pulse.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  localparam int unsigned CR_ADDR_W = 16;
  localparam int unsigned CR_DATA_W = 16;
  localparam int unsigned FSEL_W    = 3;
  localparam int unsigned STEP_W    = 2;
  localparam int unsigned NUM_STEPS = 3;
  localparam int unsigned MEAS_LSB  = 4;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  // Step addresses and fixed tuning values
  localparam logic [CR_ADDR_W-1:0] LOS_ADDR   = 16'h0015;
  localparam logic [CR_DATA_W-1:0] LOS_DATA   = 16'hA409;
  localparam logic [CR_ADDR_W-1:0] BOOST_ADDR = 16'h0012;
  localparam logic [CR_DATA_W-1:0] BOOST_DATA = 16'hA000;
  localparam logic [CR_ADDR_W-1:0] LANE_ADDR  = 16'h1010;

  // Frequency codes that pick a non-default measurement time
  localparam logic [FSEL_W-1:0] FSEL_19M2 = 3'd3;
  localparam logic [FSEL_W-1:0] FSEL_20M  = 3'd4;
  localparam logic [FSEL_W-1:0] FSEL_50M  = 3'd7;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } cal_state_t;

  function automatic logic [CR_DATA_W-1:0] meas_word(input logic [FSEL_W-1:0] code);
    logic [7:0] t;
    case (code)
      FSEL_50M:           t = 8'h20;
      FSEL_19M2, FSEL_20M: t = 8'h04;
      default:            t = 8'h08;
    endcase
    return CR_DATA_W'(t) << MEAS_LSB;
  endfunction

endpackage

// File: rtl/phy_cal_table.sv
module phy_cal_table
  import phy_cal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [FSEL_W-1:0]     freq_in,
  input  logic [STEP_W-1:0]     step_idx,
  output logic [CR_ADDR_W-1:0]  addr,
  output logic [CR_DATA_W-1:0]  data
);

  logic [FSEL_W-1:0] fsel_q;
  logic [FSEL_W-1:0] fsel_d;

  always_comb begin
    fsel_d = fsel_q;
    if (load_en) fsel_d = freq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsel_q <= '0;
    else        fsel_q <= fsel_d;
  end

  always_comb begin
    case (step_idx)
      2'd0: begin
        addr = LOS_ADDR;
        data = LOS_DATA;
      end
      2'd1: begin
        addr = BOOST_ADDR;
        data = BOOST_DATA;
      end
      default: begin
        addr = LANE_ADDR;
        data = meas_word(fsel_q);
      end
    endcase
  end

  AST_FSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> fsel_q == $past(fsel_q)) else $error("fsel changed without load"); // R9

endmodule

// File: rtl/phy_cal_ctrl.sv
module phy_cal_ctrl
  import phy_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic              cal_target,
  input  logic              port_done,
  input  logic              port_error,
  output logic              load_en,
  output logic [STEP_W-1:0] step_idx,
  output logic              port_req,
  output logic              busy,
  output logic              cal_done,
  output logic              cal_error,
  output logic [STEP_W-1:0] failed_step
);

  cal_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [STEP_W-1:0] fstep_q, fstep_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = err_q;
    fstep_d = fstep_q;
    load_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cal_start) begin
          err_d   = 1'b0;
          fstep_d = '0;
          if (!cal_target) begin
            load_en = 1'b1;
            step_d  = '0;
            state_d = ST_WRITE;
          end else begin
            done_d  = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (port_error) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
          fstep_d = STEP_W'(step_q + 2'd1);
        end else if (port_done) begin
          if (step_q == LAST_STEP) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d  = STEP_W'(step_q + 2'd1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fstep_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
      fstep_q <= fstep_d;
    end
  end

  assign step_idx    = step_q;
  assign port_req    = (state_q == ST_WRITE);
  assign busy        = (state_q == ST_WRITE);
  assign cal_done    = done_q;
  assign cal_error   = err_q;
  assign failed_step = fstep_q;

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    port_req && port_done && !port_error && step_q != LAST_STEP
    |=> port_req && step_q == STEP_W'($past(step_q) + 2'd1)) else $error("bad advance"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done) else $error("cal_done not a pulse"); // R7
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_error |-> failed_step != '0) else $error("error without step"); // R6
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    port_req && port_error |=> !port_req && cal_error && cal_done) else $error("no abort"); // R10
  AST_OTHER_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cal_start && cal_target |=> cal_done && !busy && !cal_error) else $error("other target"); // R8
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cal_start && !port_done && !port_error |=> busy && step_q == $past(step_q)) else $error("start while busy"); // R11

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_start,
  input  logic                 cal_target,
  input  logic [FSEL_W-1:0]    freq_code,
  output logic                 port_req,
  output logic [CR_ADDR_W-1:0] port_addr,
  output logic [CR_DATA_W-1:0] port_data,
  input  logic                 port_done,
  input  logic                 port_error,
  output logic                 busy,
  output logic                 cal_done,
  output logic                 cal_error,
  output logic [STEP_W-1:0]    failed_step
);

  logic              load_en;
  logic [STEP_W-1:0] step_idx;

  phy_cal_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cal_start   (cal_start),
    .cal_target  (cal_target),
    .port_done   (port_done),
    .port_error  (port_error),
    .load_en     (load_en),
    .step_idx    (step_idx),
    .port_req    (port_req),
    .busy        (busy),
    .cal_done    (cal_done),
    .cal_error   (cal_error),
    .failed_step (failed_step)
  );

  phy_cal_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .freq_in  (freq_code),
    .step_idx (step_idx),
    .addr     (port_addr),
    .data     (port_data)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    port_req && !port_done && !port_error
    |=> port_req && $stable(port_addr) && $stable(port_data)) else $error("request not held"); // R5
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !port_req) else $error("request while idle"); // R1

endmodule

// File: tb/phy_cal_seq_tb.sv
module phy_cal_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cal_start, cal_target;
  logic [2:0]  freq_code;
  logic        port_req;
  logic [15:0] port_addr, port_data;
  logic        port_done, port_error;
  logic        busy, cal_done, cal_error;
  logic [1:0]  failed_step;

  always #4 clk = ~clk;

  phy_cal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_target(cal_target),
    .freq_code(freq_code), .port_req(port_req), .port_addr(port_addr),
    .port_data(port_data), .port_done(port_done), .port_error(port_error),
    .busy(busy), .cal_done(cal_done), .cal_error(cal_error), .failed_step(failed_step)
  );

  int checks = 0;
  int fails  = 0;

  // port model state
  int          lat = 0;
  int          fail_at = 0;
  bit          both_at = 0;
  int          n_writes = 0;
  int          wait_cnt = 0;
  int          unstable = 0;
  logic [15:0] addr_log [8];
  logic [15:0] data_log [8];
  logic [15:0] hold_addr, hold_data;

  // vectors: {freq[7:5], fail_step[4:3], both[2], latency[1:0]}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {3'd7, 2'd0, 1'b0, 2'd0},
    {3'd3, 2'd0, 1'b0, 2'd1},
    {3'd4, 2'd0, 1'b0, 2'd2},
    {3'd5, 2'd0, 1'b0, 2'd0},
    {3'd0, 2'd0, 1'b0, 2'd1},
    {3'd6, 2'd0, 1'b0, 2'd0},
    {3'd5, 2'd1, 1'b0, 2'd1},
    {3'd2, 2'd2, 1'b0, 2'd0},
    {3'd7, 2'd3, 1'b0, 2'd2},
    {3'd4, 2'd2, 1'b1, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic [15:0] exp_addr(input int i);
    case (i)
      0: return 16'h0015;
      1: return 16'h0012;
      default: return 16'h1010;
    endcase
  endfunction

  function automatic logic [15:0] exp_data(input int i, input logic [2:0] f);
    if (i == 0) return 16'hA409;
    if (i == 1) return 16'hA000;
    if (f == 3'd7) return 16'h0200;
    if (f == 3'd3 || f == 3'd4) return 16'h0040;
    return 16'h0080;
  endfunction

  // port master model: responds at negedge after lat waiting cycles
  initial begin
    port_done = 1'b0;
    port_error = 1'b0;
    forever begin
      @(negedge clk);
      port_done = 1'b0;
      port_error = 1'b0;
      if (port_req) begin
        if (wait_cnt > 0 && (port_addr != hold_addr || port_data != hold_data)) unstable++;
        hold_addr = port_addr;
        hold_data = port_data;
        if (wait_cnt >= lat) begin
          if (n_writes < 8) begin
            addr_log[n_writes] = port_addr;
            data_log[n_writes] = port_data;
          end
          n_writes++;
          if (fail_at == n_writes) begin
            port_error = 1'b1;
            if (both_at) port_done = 1'b1;
          end else begin
            port_done = 1'b1;
          end
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  // returns cycles from start to cal_done (-1 on timeout)
  task automatic run_cal(input logic [2:0] f, input logic tgt, output int cyc, output bit busy_seen);
    @(negedge clk);
    n_writes = 0;
    unstable = 0;
    freq_code = f;
    cal_target = tgt;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    freq_code = ~f;           // R9: disturb the code mid-run
    busy_seen = busy;
    cyc = 0;
    while (!cal_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 100) cyc = -1;
  endtask

  initial begin
    rst_n = 1'b0;
    cal_start = 1'b0;
    cal_target = 1'b0;
    freq_code = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !port_req && !cal_done && !cal_error && failed_step == 0, "R1 reset outputs",
          {busy, port_req, cal_done, cal_error, failed_step}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !port_req && !cal_done, "R1 after release", {busy, port_req, cal_done}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] f;
      int fs, ew, cyc;
      bit bs;
      f       = VEC[v][7:5];
      fs      = int'(VEC[v][4:3]);
      both_at = VEC[v][2];
      lat     = int'(VEC[v][1:0]);
      fail_at = fs;
      ew      = (fs == 0) ? 3 : fs;
      run_cal(f, 1'b0, cyc, bs);
      check(bs, "R7 busy after start", int'(bs), 1);
      check(cyc >= 0, "R7 cal_done reached", cyc, 0);
      check(n_writes == ew, (fs == 0) ? "R5 write count" : "R6 no write after failure", n_writes, ew);
      check(unstable == 0, "R5 request held stable", unstable, 0);
      for (int i = 0; i < ew && i < 3; i++) begin
        check(addr_log[i] == exp_addr(i), i == 0 ? "R2 address" : (i == 1 ? "R3 address" : "R4 address"),
              int'(addr_log[i]), int'(exp_addr(i)));
        check(data_log[i] == exp_data(i, f), i == 0 ? "R2 data" : (i == 1 ? "R3 data" : "R9 R4 data"),
              int'(data_log[i]), int'(exp_data(i, f)));
      end
      check(cal_error == (fs != 0), both_at ? "R10 both responses fail" : "R6 R7 cal_error", int'(cal_error), int'(fs != 0));
      if (fs != 0) check(failed_step == 2'(fs), "R6 failed_step", int'(failed_step), fs);
      @(negedge clk);
      check(!cal_done && !busy && !port_req, "R7 single pulse then idle", {cal_done, busy, port_req}, 0);
      check(cal_error == (fs != 0), "R6 error held", int'(cal_error), int'(fs != 0));
    end

    // R8 other instance
    begin
      int cyc;
      bit bs;
      fail_at = 0;
      lat = 0;
      run_cal(3'd7, 1'b1, cyc, bs);
      check(cyc == 0 && !bs, "R8 immediate completion", cyc, 0);
      check(n_writes == 0 && !cal_error, "R8 no writes no error", n_writes, 0);
      cal_target = 1'b0;
    end

    // R11 start while busy
    begin
      int pulses;
      fail_at = 0;
      lat = 3;
      @(negedge clk);
      n_writes = 0;
      freq_code = 3'd4;
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      @(negedge clk);
      cal_start = 1'b1;   // while busy
      @(negedge clk);
      cal_start = 1'b0;
      pulses = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (cal_done) pulses++;
      end
      check(n_writes == 3, "R11 no extra writes", n_writes, 3);
      check(pulses == 1, "R11 single completion", pulses, 1);
      check(!busy && !port_req, "R11 idle afterwards", {busy, port_req}, 0);
    end

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule